// File: doc/BRIEF.md
# Framed Serial DAC Input Interface

This block is the digital front end of a single-channel serial-input DAC. A host writes to it over three wires: an active-low frame-select line, a serial clock and a data line. While the select line is low, one bit is taken on each falling clock edge, most significant bit first. When the last bit of a fixed-length frame arrives, the block splits the frame into a two-bit power-down field and a data field and updates the held output registers. Those registers feed the converter core, which is not part of this block.

A parameter chooses between two frame formats. One is a 16-bit frame that carries a 14-bit code. The other is a 24-bit frame that carries a 16-bit code, followed by six low bits that are ignored. If the select line returns high before the last bit, the write is abandoned and nothing changes. After reset the code is zero and the mode is normal, and both stay that way until a complete frame arrives. A power-down frame keeps the held code unchanged. A later normal-mode frame brings back normal operation with the code it carries.

Top module: `sdac_serial_if`

## Requirements
- R1: A synchronous reset (`rst` high on a falling `sclk` edge) clears `dac_code` to 0 and `pd_mode` to 2'b00. Both keep these values until a complete frame has been received.
- R2: On each falling `sclk` edge where `sync_n` is low and a frame is in progress, one bit is taken from `sdin`. The first bit taken is frame bit FRAME_W-1, the most significant bit.
- R3: Narrow variant (`WIDE_FRAME`=0, 16-bit frame): frame bits [15:14] are the mode field and bits [13:0] are the code.
- R4: Wide variant (`WIDE_FRAME`=1, 24-bit frame): frame bits [23:22] are the mode field and bits [21:6] are the code. Bits [5:0] have no effect on the outputs.
- R5: The outputs change only on the falling edge that takes the final bit of a frame, and they are updated on that edge. Before that edge, a partly received frame leaves them unchanged.
- R6: If `sync_n` is high on any falling edge before the final bit, the partial frame is discarded and the outputs keep their values. The next low period of `sync_n` starts a new frame at bit FRAME_W-1.
- R7: After the final bit, further falling edges with `sync_n` still low are ignored. A new frame can start only after `sync_n` has been high on at least one falling edge.
- R8: A frame whose mode field is 2'b01, 2'b10 or 2'b11 copies that value to `pd_mode` and leaves `dac_code` unchanged.
- R9: A frame whose mode field is 2'b00 sets `pd_mode` to 2'b00 and loads `dac_code` with the frame's code field. This is also how the block leaves a power-down mode.
- R10: Frames separated by a single falling edge with `sync_n` high are each received and committed in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; the block samples data and reset on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | CODE_W (16 or 14) | Held converter code |
| pd_mode | output | 2 | Held power-down field; 00 means normal operation |

## Verification
Both variants are driven from the same pins, so every stimulus tests the two frame lengths against each other. A 24-bit write is a full frame for the wide instance, while the narrow instance must commit its first 16 bits and ignore the rest. A 16-bit write commits in the narrow instance but is an abort for the wide one. The stimulus covers a 12-bit abort, power-down frames of each variant with a changed code, back-to-back frames with a one-edge gap, a frame that runs six bits too long, and a normal frame after power-down. Together these separate discarding a partial frame from committing it, keeping the code from loading it during power-down, and respecting the final-edge boundary from miscounting by one. A behavioural queue model is compared with both instances on every clock.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        PD_OFF       = 2'b00,
        PD_LOAD_LOW  = 2'b01,
        PD_LOAD_HIGH = 2'b10,
        PD_FLOAT     = 2'b11
    } pd_mode_e;

    localparam int MODE_W   = 2;
    localparam int CODE_MAX = 16;

    typedef struct packed {
        pd_mode_e              mode;
        logic [CODE_MAX-1:0]   code;
    } sdac_cmd_t;

    function automatic int frame_bits(input bit wide);
        return wide ? 24 : 16;
    endfunction

    function automatic int code_bits(input bit wide);
        return wide ? 16 : 14;
    endfunction

endpackage

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int FRAME_W = 24
) (
    input  logic               sclk,
    input  logic               rst,
    input  logic               sync_n,
    input  logic               sdin,
    output logic [FRAME_W-1:0] frame_word,
    output logic               frame_last
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-2:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic               armed;

    assign frame_last = !sync_n && armed && (cnt == LAST);
    assign frame_word = {sh, sdin};

    always_ff @(negedge sclk) begin
        if (rst) begin
            sh    <= '0;
            cnt   <= '0;
            armed <= 1'b1;
        end else if (sync_n) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (armed) begin
            sh <= {sh[FRAME_W-3:0], sdin};
            if (cnt == LAST) begin
                cnt   <= '0;
                armed <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_cnt_bound_R5: assert property (@(negedge sclk) disable iff (rst)
        cnt <= LAST);

    assert_sync_rearm_R6: assert property (@(negedge sclk) disable iff (rst)
        sync_n |=> (cnt == '0) && armed);

    assert_done_disarm_R7: assert property (@(negedge sclk) disable iff (rst)
        frame_last |=> !armed);

    assert_stay_idle_R7: assert property (@(negedge sclk) disable iff (rst)
        (!armed && !sync_n) |=> !armed && (cnt == '0));

endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
    import sdac_pkg::*;
#(
    parameter bit WIDE_FRAME = 1'b1
) (
    input  logic [frame_bits(WIDE_FRAME)-1:0] frame_word,
    output sdac_cmd_t                         cmd
);
    localparam int FRAME_W = frame_bits(WIDE_FRAME);
    localparam int CODE_W  = code_bits(WIDE_FRAME);
    localparam int PAD_W   = FRAME_W - MODE_W - CODE_W;

    logic [CODE_MAX-1:0] code_f;

    generate
        if (WIDE_FRAME) begin : g_wide
            logic [PAD_W-1:0] unused_low;
            assign unused_low = frame_word[PAD_W-1:0];
            assign code_f = frame_word[FRAME_W-MODE_W-1 -: CODE_W];
        end else begin : g_narrow
            assign code_f = {{(CODE_MAX-CODE_W){1'b0}}, frame_word[CODE_W-1:0]};
        end
    endgenerate

    always_comb begin
        cmd.mode = pd_mode_e'(frame_word[FRAME_W-1 -: MODE_W]);
        cmd.code = code_f;
    end

endmodule

// File: rtl/sdac_hold.sv
module sdac_hold
    import sdac_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              commit,
    input  sdac_cmd_t         cmd,
    output logic [CODE_W-1:0] code_q,
    output pd_mode_e          mode_q
);
    logic unused_pad;
    assign unused_pad = ^cmd.code;

    always_ff @(negedge sclk) begin
        if (rst) begin
            code_q <= '0;
            mode_q <= PD_OFF;
        end else if (commit) begin
            mode_q <= cmd.mode;
            if (cmd.mode == PD_OFF) begin
                code_q <= cmd.code[CODE_W-1:0];
            end
        end
    end

    assert_hold_idle_R5: assert property (@(negedge sclk) disable iff (rst)
        !commit |=> $stable(code_q) && $stable(mode_q));

    assert_pd_keeps_code_R8: assert property (@(negedge sclk) disable iff (rst)
        (commit && cmd.mode != PD_OFF) |=> $stable(code_q) && (mode_q != PD_OFF));

    assert_normal_loads_R9: assert property (@(negedge sclk) disable iff (rst)
        (commit && cmd.mode == PD_OFF) |=> (mode_q == PD_OFF) &&
        (code_q == $past(cmd.code[CODE_W-1:0])));

endmodule

// File: rtl/sdac_serial_if.sv
module sdac_serial_if
    import sdac_pkg::*;
#(
    parameter bit WIDE_FRAME = 1'b1,
    localparam int FRAME_W = frame_bits(WIDE_FRAME),
    localparam int CODE_W  = code_bits(WIDE_FRAME)
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              sdin,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        pd_mode
);
    logic [FRAME_W-1:0] frame_word;
    logic               frame_last;
    sdac_cmd_t          cmd;
    pd_mode_e           mode_q;

    sdac_shift #(.FRAME_W(FRAME_W)) u_shift (
        .sclk       (sclk),
        .rst        (rst),
        .sync_n     (sync_n),
        .sdin       (sdin),
        .frame_word (frame_word),
        .frame_last (frame_last)
    );

    sdac_decode #(.WIDE_FRAME(WIDE_FRAME)) u_decode (
        .frame_word (frame_word),
        .cmd        (cmd)
    );

    sdac_hold #(.CODE_W(CODE_W)) u_hold (
        .sclk   (sclk),
        .rst    (rst),
        .commit (frame_last),
        .cmd    (cmd),
        .code_q (dac_code),
        .mode_q (mode_q)
    );

    assign pd_mode = mode_q;

    assert_abort_quiet_R6: assert property (@(negedge sclk) disable iff (rst)
        sync_n |=> $stable(dac_code) && $stable(pd_mode));

endmodule

// File: tb/sdac_serial_if_tb_top.sv
`timescale 1ns/1ps
module sdac_serial_if_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n = 1'b1;
    logic sdin = 1'b0;
    logic [15:0] code_w;
    logic [13:0] code_n;
    logic [1:0]  mode_w, mode_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sdac_serial_if #(.WIDE_FRAME(1'b1)) dut_i (
        .sclk(clk), .rst(rst), .sync_n(sync_n), .sdin(sdin),
        .dac_code(code_w), .pd_mode(mode_w));

    sdac_serial_if #(.WIDE_FRAME(1'b0)) dut_n (
        .sclk(clk), .rst(rst), .sync_n(sync_n), .sdin(sdin),
        .dac_code(code_n), .pd_mode(mode_n));

    // behavioural reference: bit queues, integer fields
    bit q_w[$];
    bit q_n[$];
    bit arm_w = 1'b1, arm_n = 1'b1;
    int mc_w = 0, mm_w = 0, mc_n = 0, mm_n = 0;

    task automatic model_step(ref bit q[$], ref bit arm, ref int mc, ref int mm,
                              input int n, input int cw);
        int v;
        if (rst) begin
            q.delete(); arm = 1'b1; mc = 0; mm = 0;
        end else if (sync_n) begin
            q.delete(); arm = 1'b1;
        end else if (arm) begin
            q.push_back(sdin);
            if (q.size() == n) begin
                v = 0;
                foreach (q[k]) v = v * 2 + int'(q[k]);
                mm = v >> (n - 2);
                if (mm == 0) mc = (v >> (n - 2 - cw)) & ((1 << cw) - 1);
                q.delete();
                arm = 1'b0;
            end
        end
    endtask

    always @(negedge clk) begin
        model_step(q_w, arm_w, mc_w, mm_w, 24, 16);
        model_step(q_n, arm_n, mc_n, mm_n, 16, 14);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cmp_on && !done) begin
            chk(cur_req, "model code wide", int'(code_w), mc_w);
            chk(cur_req, "model mode wide", int'(mode_w), mm_w);
            chk(cur_req, "model code narrow", int'(code_n), mc_n);
            chk(cur_req, "model mode narrow", int'(mode_n), mm_n);
        end
    end

    task automatic send(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(posedge clk);
            sync_n = 1'b0;
            sdin = w[i];
        end
        @(posedge clk);
        sync_n = 1'b1;
        sdin = 1'b0;
        #1;
    endtask

    task automatic expect4(input string req, input int cw, input int mw,
                           input int cn, input int mn);
        chk(req, "code wide", int'(code_w), cw);
        chk(req, "mode wide", int'(mode_w), mw);
        chk(req, "code narrow", int'(code_n), cn);
        chk(req, "mode narrow", int'(mode_n), mn);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1: power-on default, idle clocks with data toggling and sync high
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            sdin = ~sdin;
        end
        #1;
        expect4("R1", 0, 0, 0, 0);

        // R2 R4 R9: full wide frame, low pad bits set; narrow takes top 16 (R7)
        cur_req = "R4";
        send(32'h2970FF, 24);
        expect4("R4", 16'hA5C3, 0, 14'h2970, 0);

        // R6: 12-bit abort in both variants
        cur_req = "R6";
        send(32'hFFF, 12);
        expect4("R6", 16'hA5C3, 0, 14'h2970, 0);

        // R3: 16-bit frame; narrow commits, wide aborts (R6)
        cur_req = "R3";
        send(32'h1ABC, 16);
        expect4("R3", 16'hA5C3, 0, 14'h1ABC, 0);

        // R8: power-down mode 10 with different code field
        cur_req = "R8";
        send(32'h848D00, 24);
        expect4("R8", 16'hA5C3, 2, 14'h1ABC, 2);

        // R10: back-to-back frames, modes 01 then 11, one edge gap
        cur_req = "R10";
        send(32'h455500, 24);
        expect4("R10", 16'hA5C3, 1, 14'h1ABC, 1);
        send(32'hC0FFC0, 24);
        expect4("R10", 16'hA5C3, 3, 14'h1ABC, 3);

        // R9: exit power-down with new data
        cur_req = "R9";
        send(32'h169695, 24);
        expect4("R9", 16'h5A5A, 0, 14'h1696, 0);

        // R7: frame held six bits too long; extra bits ignored
        cur_req = "R7";
        send(32'hBEEF03F, 30);
        expect4("R7", 16'hBEEF, 0, 14'h2FBB, 0);

        // R2: MSB-first order, single set bit at the top of the code field
        cur_req = "R2";
        send(32'h200000, 24);
        expect4("R2", 16'h8000, 0, 14'h2000, 0);

        // R5: mid-frame outputs unchanged
        cur_req = "R5";
        for (int i = 23; i >= 10; i--) begin
            @(posedge clk);
            sync_n = 1'b0;
            sdin = 1'b1;
        end
        #1;
        chk("R5", "mid-frame code wide", int'(code_w), 16'h8000);
        chk("R5", "mid-frame mode wide", int'(mode_w), 0);
        @(posedge clk);
        sync_n = 1'b1;
        #1;

        // R1: reset after activity
        cur_req = "R1";
        @(posedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        expect4("R1", 0, 0, 0, 0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule